// File: doc/BRIEF.md
# Multi-Mode Serial Flash Byte Reader

This block fetches one byte at a time from a serial NOR flash under register control. Software first sets up the read opcode, the flash address and the lane configuration. It then writes the start code to the control register. The block drives chip select low and sends the opcode on one line. It sends the address on one, two or four lines, and adds dummy clocks when the configuration calls for them. It then samples one data byte on one, two or four lines.

When the byte is complete, it goes into the captured-byte register. In the same cycle the 32-bit address register steps by one and the control register returns to zero. A stream of bytes therefore needs only one start write per byte. The address does not have to be reprogrammed between bytes.

The serial clock runs at half the system clock rate. Each serial clock takes one system cycle low and one system cycle high. Output bits change while the serial clock is falling. Input bits are sampled at its rising edge.

Top module: `flash_byte_reader`

## Requirements
- R1: After reset, every register reads 0x00. Chip select is high, the serial clock is low and no lane is driven.
- R2: Writing 0x81 to the control register (offset 0x00) starts one byte read. The control register reads 0x81 while the read runs and 0x00 from the cycle the byte lands in the captured-byte register (offset 0x0C). Any other value written there is ignored.
- R3: A read frame sends the 8-bit opcode first, MSB first, on lane 0 alone. The address follows MSB first. The four address bytes are at offsets 0x10 (bits 7:0), 0x14 (15:8), 0x18 (23:16) and 0xC8 (31:24). Only the low 24 bits are sent unless bit 4 of the lane register (offset 0xCC) is set, in which case all 32 bits are sent.
- R4: The opcode comes from offset 0x2C when bit 2 of the lane register is clear, and from offset 0x30 when it is set.
- R5: Data lane selection uses bits of the lane register. Bit 2 selects four lanes (io[3:0], 2 clocks per byte) and takes priority over bit 0. Bit 0 selects two lanes (io[1:0], 4 clocks). When neither is set, data comes on io[1] alone over 8 clocks. Data arrives MSB first, with the higher-order bit on the higher-numbered lane.
- R6: Address lane selection uses bits of the lane register. Bit 3 selects four lanes and takes priority over bit 1. Bit 1 selects two lanes. When neither is set, the address goes out on lane 0.
- R7: 8 dummy clocks follow the address in three cases: bit 0 of the timing register (offset 0x60) is set, or the data phase uses two lanes, or it uses four lanes. No lane is driven during the dummy clocks or the data phase.
- R8: The serial clock is low whenever chip select is high. A read of N serial clocks keeps the control register busy for exactly 2N+1 system cycles after the start edge.
- R9: Each completed byte adds one to the full 32-bit address, with the carry propagating across the byte registers.
- R10: Register writes made while a read is in progress are ignored, including another start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| flash_sck | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_io_out | output | 4 | Lane output values |
| flash_io_oe | output | 4 | Per-lane output enables |
| flash_io_in | input | 4 | Lane input values |

## Verification
Every result appears one system cycle after the last falling edge of the serial clock. At that edge the busy flag drops, the captured byte becomes readable and the address has stepped. This happens exactly 2N+1 clock edges after the edge that accepted the start code, where N is 8 for the opcode, plus the address clocks, plus the dummy clocks, plus the data clocks.

The bench counts rising edges from the start edge and reads the control register half a cycle after each one. It compares the count at which busy first reads zero with the value from that sum for each lane configuration, and reads the byte and address only after that point. The flash model samples at rising serial-clock edges and changes its lanes at falling ones. That keeps a full system cycle between a lane change and its capture by the design.

// File: rtl/fbr_pkg.sv
// Shared constants and types for the serial flash byte reader.
// Assumes an 8-bit register offset space and byte-wide registers.
package fbr_pkg;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_RXBYTE   = 8'h0C;
    localparam logic [7:0] OFS_OPC_STD  = 8'h2C;
    localparam logic [7:0] OFS_OPC_QUAD = 8'h30;
    localparam logic [7:0] OFS_TIMING   = 8'h60;
    localparam logic [7:0] OFS_LANES    = 8'hCC;
    localparam int         ADDR_BYTES   = 4;
    localparam logic [7:0] OFS_ADR [ADDR_BYTES] = '{8'h10, 8'h14, 8'h18, 8'hC8};

    localparam logic [7:0] CMD_READ_BYTE = 8'h81;

    localparam int LB_DUAL_DATA = 0;
    localparam int LB_DUAL_ADDR = 1;
    localparam int LB_QUAD_DATA = 2;
    localparam int LB_QUAD_ADDR = 3;
    localparam int LB_WIDE_ADDR = 4;
    localparam int LANE_REG_W   = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDRESS,
        PH_DUMMY,
        PH_DATA,
        PH_WRAP
    } seq_state_e;

    typedef struct packed {
        logic [7:0]              opcode;
        logic [8*ADDR_BYTES-1:0] address;
        logic                    wide_addr;
        logic [1:0]              addr_lsh;
        logic [1:0]              data_lsh;
        logic                    dummy_en;
    } rd_cfg_t;

    // log2 of the lane count; the four-lane bit wins over the two-lane bit
    function automatic logic [1:0] lane_shift(input logic dual, input logic quad);
        return quad ? 2'd2 : (dual ? 2'd1 : 2'd0);
    endfunction

endpackage

// File: rtl/fbr_regs.sv
// Register file of the flash byte reader.
// Holds opcodes, address, timing and lane settings and the captured byte.
// Assumes the sequencer raises seq_done for exactly one cycle per started read.
// All writes are refused while busy is high.
module fbr_regs
    import fbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       seq_done,
    input  logic [7:0] seq_rx,
    output logic       start,
    output logic       busy,
    output rd_cfg_t    cfg
);

    localparam int AW = 8 * ADDR_BYTES;

    logic [7:0]            opc_std_q, opc_quad_q, rxbyte_q;
    logic                  timing_q;
    logic [LANE_REG_W-1:0] lanes_q;
    logic [AW-1:0]         addr_q;

    // Start pulse: the start code written to the control register while idle
    assign start = reg_we && !busy && (reg_addr == OFS_CTRL) && (reg_wdata == CMD_READ_BYTE);

    // Register updates: completion first, otherwise software writes while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_std_q  <= '0;
            opc_quad_q <= '0;
            rxbyte_q   <= '0;
            timing_q   <= 1'b0;
            lanes_q    <= '0;
            addr_q     <= '0;
            busy       <= 1'b0;
        end else if (seq_done) begin
            busy     <= 1'b0;
            rxbyte_q <= seq_rx;
            addr_q   <= addr_q + AW'(1);
        end else if (reg_we && !busy) begin
            if (start)                      busy       <= 1'b1;
            if (reg_addr == OFS_OPC_STD)    opc_std_q  <= reg_wdata;
            if (reg_addr == OFS_OPC_QUAD)   opc_quad_q <= reg_wdata;
            if (reg_addr == OFS_TIMING)     timing_q   <= reg_wdata[0];
            if (reg_addr == OFS_LANES)      lanes_q    <= reg_wdata[LANE_REG_W-1:0];
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (reg_addr == OFS_ADR[b]) addr_q[8*b +: 8] <= reg_wdata;
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_addr)
            OFS_CTRL:     reg_rdata = busy ? CMD_READ_BYTE : 8'h00;
            OFS_RXBYTE:   reg_rdata = rxbyte_q;
            OFS_OPC_STD:  reg_rdata = opc_std_q;
            OFS_OPC_QUAD: reg_rdata = opc_quad_q;
            OFS_TIMING:   reg_rdata = {7'h00, timing_q};
            OFS_LANES:    reg_rdata = {{(8-LANE_REG_W){1'b0}}, lanes_q};
            default: begin
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (reg_addr == OFS_ADR[b]) reg_rdata = addr_q[8*b +: 8];
                end
            end
        endcase
    end

    // Read configuration handed to the sequencer
    always_comb begin
        cfg.opcode    = lanes_q[LB_QUAD_DATA] ? opc_quad_q : opc_std_q;
        cfg.address   = addr_q;
        cfg.wide_addr = lanes_q[LB_WIDE_ADDR];
        cfg.addr_lsh  = lane_shift(lanes_q[LB_DUAL_ADDR], lanes_q[LB_QUAD_ADDR]);
        cfg.data_lsh  = lane_shift(lanes_q[LB_DUAL_DATA], lanes_q[LB_QUAD_DATA]);
        cfg.dummy_en  = timing_q | lanes_q[LB_DUAL_DATA] | lanes_q[LB_QUAD_DATA];
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> addr_q == $past(addr_q) + AW'(1)); // R9
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> ($stable(lanes_q) && $stable(opc_std_q) && $stable(opc_quad_q)
                                && $stable(timing_q) && $stable(addr_q))); // R10
    AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> busy); // R2

endmodule

// File: rtl/fbr_seq.sv
// Serial frame sequencer for one byte read.
// Runs the opcode, address, optional dummy and data phases at half the system clock rate.
// Each serial clock is one low cycle followed by one high cycle.
// Outputs shift while the serial clock falls; inputs are sampled as it rises.
// Assumes cfg stays stable from start until done.
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int DUMMY_CLKS = 8,
    parameter int CNT_W      = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  rd_cfg_t    cfg,
    input  logic [3:0] io_in,
    output logic       sck,
    output logic       cs_n,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int AW        = 8 * ADDR_BYTES;
    localparam int STD_BITS  = AW - 8;
    localparam int BYTE_BITS = 8;

    seq_state_e       state;
    logic             ph;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    tx;
    logic [7:0]       rx, rx_next;
    logic [1:0]       lsh;
    logic [2:0]       lane_n;

    // Serial clocks needed for a bit count at a given lane width, minus one
    function automatic logic [CNT_W-1:0] span(input int bits, input logic [1:0] s);
        return CNT_W'((bits >> s) - 1);
    endfunction

    assign lane_n = 3'd1 << lsh;

    // Next capture value for the active data lane width
    always_comb begin
        unique case (lsh)
            2'd0:    rx_next = {rx[6:0], io_in[1]};
            2'd1:    rx_next = {rx[5:0], io_in[1:0]};
            default: rx_next = {rx[3:0], io_in};
        endcase
    end

    // Phase walk, bit counting, shifting out and capturing in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            ph    <= 1'b0;
            cnt   <= '0;
            tx    <= '0;
            rx    <= '0;
            lsh   <= 2'd0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    if (start) begin
                        state <= PH_OPCODE;
                        ph    <= 1'b0;
                        cnt   <= span(BYTE_BITS, 2'd0);
                        tx    <= {cfg.opcode, {(AW-8){1'b0}}};
                        lsh   <= 2'd0;
                    end
                end
                PH_WRAP: state <= PH_IDLE;
                default: begin
                    ph <= ~ph;
                    if (!ph && state == PH_DATA) rx <= rx_next;
                    if (ph) begin
                        if (cnt != '0) begin
                            cnt <= cnt - CNT_W'(1);
                            tx  <= tx << lane_n;
                        end else begin
                            unique case (state)
                                PH_OPCODE: begin
                                    state <= PH_ADDRESS;
                                    lsh   <= cfg.addr_lsh;
                                    tx    <= cfg.wide_addr ? cfg.address
                                                           : {cfg.address[STD_BITS-1:0], 8'h00};
                                    cnt   <= span(cfg.wide_addr ? AW : STD_BITS, cfg.addr_lsh);
                                end
                                PH_ADDRESS: begin
                                    lsh <= cfg.data_lsh;
                                    if (cfg.dummy_en) begin
                                        state <= PH_DUMMY;
                                        cnt   <= CNT_W'(DUMMY_CLKS - 1);
                                    end else begin
                                        state <= PH_DATA;
                                        cnt   <= span(BYTE_BITS, cfg.data_lsh);
                                    end
                                end
                                PH_DUMMY: begin
                                    state <= PH_DATA;
                                    cnt   <= span(BYTE_BITS, lsh);
                                end
                                default: state <= PH_WRAP;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Lane drive during the opcode and address phases only
    always_comb begin
        io_out = 4'h0;
        io_oe  = 4'h0;
        if (state == PH_OPCODE || state == PH_ADDRESS) begin
            unique case (lsh)
                2'd0:    begin io_out[0]   = tx[AW-1];         io_oe = 4'b0001; end
                2'd1:    begin io_out[1:0] = tx[AW-1 -: 2];    io_oe = 4'b0011; end
                default: begin io_out      = tx[AW-1 -: 4];    io_oe = 4'b1111; end
            endcase
        end
    end

    assign cs_n    = (state == PH_IDLE) || (state == PH_WRAP);
    assign sck     = ph && !cs_n;
    assign done    = (state == PH_WRAP);
    assign rx_byte = rx;

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state == PH_IDLE); // R2
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && io_oe == 4'h0)); // R8
    AST_OPCODE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_OPCODE |-> io_oe == 4'b0001); // R3
    AST_RELEASE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DUMMY || state == PH_DATA) |-> io_oe == 4'h0); // R7
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

endmodule

// File: rtl/flash_byte_reader.sv
// Top of the serial flash byte reader.
// Joins the register file to the frame sequencer.
// Assumes a single attached flash and a synchronous active-low reset.
module flash_byte_reader
    import fbr_pkg::*;
#(
    parameter int DUMMY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       flash_sck,
    output logic       flash_cs_n,
    output logic [3:0] flash_io_out,
    output logic [3:0] flash_io_oe,
    input  logic [3:0] flash_io_in
);

    logic       start, busy, seq_done;
    logic [7:0] seq_rx;
    rd_cfg_t    cfg;

    fbr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .seq_done  (seq_done),
        .seq_rx    (seq_rx),
        .start     (start),
        .busy      (busy),
        .cfg       (cfg)
    );

    fbr_seq #(.DUMMY_CLKS(DUMMY_CLKS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cfg     (cfg),
        .io_in   (flash_io_in),
        .sck     (flash_sck),
        .cs_n    (flash_cs_n),
        .io_out  (flash_io_out),
        .io_oe   (flash_io_oe),
        .done    (seq_done),
        .rx_byte (seq_rx)
    );

    AST_BUSY_MATCHES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> busy); // R2

endmodule

// File: tb/sim_flash_byte_reader.sv
module sim_flash_byte_reader;

    localparam logic [7:0] A_CTRL = 8'h00, A_RX = 8'h0C, A_OPS = 8'h2C, A_OPQ = 8'h30;
    localparam logic [7:0] A_TIM = 8'h60, A_LANE = 8'hCC;
    localparam logic [7:0] A_ADR [4] = '{8'h10, 8'h14, 8'h18, 8'hC8};
    localparam logic [7:0] OPS = 8'h0B, OPQ = 8'h6B;
    localparam int NV = 11;
    // {lane reg, timing reg, address, expected busy cycles}
    localparam logic [55:0] VEC [NV] = '{
        {8'h00, 8'h00, 32'h0001_2345, 8'd81},
        {8'h00, 8'h01, 32'h0000_A0F1, 8'd97},
        {8'h01, 8'h00, 32'h003C_5A96, 8'd89},
        {8'h03, 8'h00, 32'h0080_0001, 8'd65},
        {8'h04, 8'h00, 32'h0012_34FE, 8'd85},
        {8'h0C, 8'h00, 32'h00FF_FF00, 8'd49},
        {8'h10, 8'h00, 32'h1234_5678, 8'd97},
        {8'h1C, 8'h01, 32'hA5C3_E10F, 8'd53},
        {8'h12, 8'h01, 32'h0000_BEEF, 8'd81},
        {8'h05, 8'h00, 32'h0000_007F, 8'd85},
        {8'h01, 8'h01, 32'h0001_2121, 8'd89}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic flash_sck, flash_cs_n;
    logic [3:0] flash_io_out, flash_io_oe;
    logic [3:0] fl_io = 4'h0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    flash_byte_reader u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_sck(flash_sck),
        .flash_cs_n(flash_cs_n), .flash_io_out(flash_io_out),
        .flash_io_oe(flash_io_oe), .flash_io_in(fl_io)
    );

    function automatic logic [7:0] memf(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int fm_n = 0, fm_al = 1, fm_ac = 24, fm_dc = 0, fm_dl = 1, fm_oe_bad = 0;
    logic [7:0]  fm_opc = 8'h00, fm_byte = 8'h00;
    logic [31:0] fm_addr = 32'h0;

    always @(negedge flash_cs_n or posedge flash_sck) begin
        if (!flash_sck) begin
            fm_n = 0; fm_opc = 8'h00; fm_addr = 32'h0;
        end else begin
            if (fm_n < 8) begin
                fm_opc = {fm_opc[6:0], flash_io_out[0]};
                if (flash_io_oe !== 4'b0001) fm_oe_bad++;
            end else if (fm_n < 8 + fm_ac) begin
                fm_addr = (fm_addr << fm_al) | (32'(flash_io_out) & ((32'd1 << fm_al) - 1));
                if (fm_n == 8 + fm_ac - 1) fm_byte = memf(fm_addr);
            end else if (flash_io_oe !== 4'b0000) begin
                fm_oe_bad++;
            end
            fm_n++;
        end
    end

    always @(negedge flash_sck) begin
        int k;
        logic [7:0] sh;
        k = fm_n - (8 + fm_ac + fm_dc);
        if (!flash_cs_n && k >= 0 && k < 8 / fm_dl) begin
            sh = fm_byte << (k * fm_dl);
            case (fm_dl)
                1:       fl_io = {2'b00, sh[7], 1'b0};
                2:       fl_io = {2'b00, sh[7:6]};
                default: fl_io = sh[7:4];
            endcase
        end else begin
            fl_io = 4'h0;
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic program_read(input logic [7:0] mode, input logic [7:0] tim, input logic [31:0] a);
        wr(A_LANE, mode);
        wr(A_TIM, tim);
        for (int b = 0; b < 4; b++) wr(A_ADR[b], a[8*b +: 8]);
        fm_al = mode[3] ? 4 : (mode[1] ? 2 : 1);
        fm_ac = (mode[4] ? 32 : 24) / fm_al;
        fm_dl = mode[2] ? 4 : (mode[0] ? 2 : 1);
        fm_dc = (tim[0] || mode[0] || mode[2]) ? 8 : 0;
    endtask

    task automatic run_read(input logic [7:0] mode, input logic [31:0] a, input int exp_cyc);
        int cyc;
        int bad0;
        logic [7:0] v;
        logic [31:0] sent, nxt;
        bad0 = fm_oe_bad;
        sent = mode[4] ? a : {8'h00, a[23:0]};
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h81;
        @(posedge clk);
        #1 reg_we = 1'b0;
        cyc = 0;
        for (int w = 0; w < 1000; w++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            #1;
            if (reg_rdata == 8'h00) break;
        end
        chk("R8 busy cycles", cyc, exp_cyc);
        chk("R4 opcode seen by flash", fm_opc, mode[2] ? OPQ : OPS);
        chk("R3/R6 address seen by flash", fm_addr, sent);
        rd(A_RX, v);
        chk("R5 captured byte", v, memf(sent));
        chk("R7 lane drive in dummy/data", fm_oe_bad - bad0, 0);
        for (int b = 0; b < 4; b++) begin
            rd(A_ADR[b], v);
            nxt[8*b +: 8] = v;
        end
        chk("R9 next address", nxt, a + 32'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1_500_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [7:0] v;
        logic [7:0] m, t;
        logic [31:0] a;
        int ec;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n idle", flash_cs_n, 1'b1);
        chk("R1 sck idle", flash_sck, 1'b0);
        chk("R1 no lane driven", flash_io_oe, 4'h0);
        rst_n = 1'b1;
        begin
            logic [7:0] offs [10];
            offs = '{A_CTRL, A_RX, A_OPS, A_OPQ, A_TIM, A_LANE, A_ADR[0], A_ADR[1], A_ADR[2], A_ADR[3]};
            for (int i = 0; i < 10; i++) begin
                rd(offs[i], v);
                chk("R1 register reset value", v, 8'h00);
            end
        end
        wr(A_OPS, OPS);
        wr(A_OPQ, OPQ);

        // table of lane/timing configurations
        for (int i = 0; i < NV; i++) begin
            m  = VEC[i][55:48];
            t  = VEC[i][47:40];
            a  = VEC[i][39:8];
            ec = int'(VEC[i][7:0]);
            program_read(m, t, a);
            run_read(m, a, ec);
        end

        // R2: a code other than the start code is ignored
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v);
        chk("R2 non-start code ignored", v, 8'h00);
        repeat (4) @(negedge clk);
        chk("R2 no frame after non-start code", flash_cs_n, 1'b1);

        // R9: carry across the byte registers, then the next byte in sequence
        program_read(8'h00, 8'h00, 32'h00FF_FFFF);
        run_read(8'h00, 32'h00FF_FFFF, 81);
        run_read(8'h00, 32'h0100_0000, 81);

        // R10: writes during a read are ignored
        program_read(8'h00, 8'h01, 32'h0000_0040);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h81;
        @(negedge clk);
        reg_we = 1'b0;
        wr(A_ADR[0], 8'hEE);
        wr(A_LANE, 8'h04);
        wr(A_OPS, 8'h99);
        wr(A_CTRL, 8'h81);
        for (int w = 0; w < 1000; w++) begin
            rd(A_CTRL, v);
            if (v == 8'h00) break;
        end
        rd(A_ADR[0], v);
        chk("R10 address write ignored while busy", v, 8'h41);
        rd(A_LANE, v);
        chk("R10 lane write ignored while busy", v, 8'h00);
        rd(A_OPS, v);
        chk("R10 opcode write ignored while busy", v, OPS);
        rd(A_RX, v);
        chk("R10 byte from unchanged address", v, memf(32'h40));
        repeat (6) @(negedge clk);
        chk("R10 second start ignored", flash_cs_n, 1'b1);

        // R1: reset again clears the programmed state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_ADR[0], v);
        chk("R1 address cleared by reset", v, 8'h00);
        rd(A_OPS, v);
        chk("R1 opcode cleared by reset", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule